// File: doc/BRIEF.md
# Cache-Line Miss Fill Buffer

This block sits between a first-level data cache and the next level of the memory hierarchy. It tracks each cache line that is currently being fetched or upgraded after a first-level miss. A small, fully associative array of line-sized entries holds these lines, with 12 entries by default. The requester presents a line address, a request kind, and an optional set of store bytes. The block does one of two things. If an entry already follows that line, the request folds into that entry. Otherwise the request claims the lowest-numbered free entry. Because store bytes can be absorbed into the entry, the store buffer slot can be released before the line arrives.

Each entry runs its own four-state machine:

- **IDLE** is the free state.
- **ISSUE** means a downstream request is waiting to be sent.
- **WAIT** means the request is outstanding.
- **INSTALL** means the line is ready to be written into the first-level cache.

The transitions are as follows:

- IDLE→ISSUE when the entry is claimed.
- ISSUE→WAIT when downstream accepts the request.
- WAIT→INSTALL when a response returns.
- WAIT→ISSUE when a response returns to a read-only entry that has since absorbed a store, so a second, ownership-only request is still needed.
- INSTALL→IDLE when the install beat is driven.

The downstream tag is the entry index, and responses are steered back by that tag. A response to a read or to an ownership fetch carries the whole line. A response to an upgrade carries only the grant. During install, absorbed store bytes override the returned bytes.

Top module: `miss_fill_buffer`

## Requirements
- R1: After reset, `req_ready` is 1, `dn_valid` is 0 and `fill_valid` is 0.
- R2: A request for a line no entry holds takes the lowest free entry. It then drives one downstream request with that line, the request's kind, and `dn_tag` equal to the entry index. The kind encodings are read = 2'b00, upgrade-from-Shared = 2'b01 and ownership fetch = 2'b10.
- R3: A request for a line that an entry already holds never allocates a second entry. Its store bytes join that entry.
- R4: A read followed by a store to the same line, before the read is sent, produces exactly one downstream request, of kind 2'b10.
- R5: A store that merges after a read was already sent causes no request at once. After the read response, exactly one extra request of kind 2'b01 is sent with the same tag. The install then happens only after that request is granted.
- R6: When the returned line carries data, the install has `fill_byte_en` all ones. In `fill_data`, every byte whose bit is set in the merged store mask (bit b covers byte b) holds the store byte, and every other byte holds the returned byte.
- R7: For an upgrade answered without data, the install has `fill_byte_en` equal to the store mask and `fill_excl` equal to 1. The enabled bytes of `fill_data` carry the store bytes.
- R8: A read-only entry installs with `fill_excl` equal to 0 and `fill_byte_en` all ones. An entry that took ownership installs with `fill_excl` equal to 1.
- R9: When all entries are busy, `req_ready` is 0 for a line that no entry holds. It stays 1 for a line that an entry holds.
- R10: A request for a line whose entry is in its install cycle sees `req_ready` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_line | input | LINE_AW | Line address of the request |
| req_kind | input | 2 | 00 read, 01 upgrade, 10 ownership fetch |
| req_mask | input | LINE_BYTES | Store byte mask (zero for reads) |
| req_data | input | LINE_BYTES*8 | Store bytes placed at their line offsets |
| dn_valid | output | 1 | Downstream request present |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_line | output | LINE_AW | Line address sent downstream |
| dn_kind | output | 2 | Kind sent downstream |
| dn_tag | output | TAG_W | Entry index carried as tag |
| rsp_valid | input | 1 | Downstream response present |
| rsp_tag | input | TAG_W | Entry the response belongs to |
| rsp_has_data | input | 1 | Response carries a full line |
| rsp_data | input | LINE_BYTES*8 | Returned line |
| fill_valid | output | 1 | Install beat to the first-level cache |
| fill_line | output | LINE_AW | Line being installed |
| fill_data | output | LINE_BYTES*8 | Install data, store bytes merged |
| fill_byte_en | output | LINE_BYTES | Bytes to write |
| fill_excl | output | 1 | Line installed writable |

## Verification
The hardest state to reach from the ports is the WAIT→ISSUE path. It requires a read that is already in flight to absorb a store before its response arrives. The bench first grants the read downstream. It then presents the store to the same line while withholding the response, and confirms that no new request appears. Only then does it return the read data and expect the ownership-only request rather than an install. The one-cycle install window of R10 is hit by presenting a request for that line in the cycle right after the response edge.

// File: rtl/mfb_pkg.sv
package mfb_pkg;
    typedef enum logic [1:0] {
        K_READ = 2'b00,
        K_UPG  = 2'b01,
        K_RFO  = 2'b10
    } kind_t;

    typedef enum logic [1:0] {
        E_IDLE,
        E_ISSUE,
        E_WAIT,
        E_INSTALL
    } est_t;

    function automatic kind_t kind_max(input kind_t a, input kind_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/mfb_pick.sv
module mfb_pick #(
    parameter int N  = 12,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/mfb_entry.sv
module mfb_entry
    import mfb_pkg::*;
#(
    parameter int LINE_AW    = 26,
    parameter int LINE_BYTES = 16,
    localparam int DW = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc,
    input  logic                  merge,
    input  logic [LINE_AW-1:0]    in_line,
    input  kind_t                 in_kind,
    input  logic [LINE_BYTES-1:0] in_mask,
    input  logic [DW-1:0]         in_data,
    input  logic                  issue_gnt,
    input  logic                  rsp_hit,
    input  logic                  rsp_has_data,
    input  logic [DW-1:0]         rsp_data,
    input  logic                  inst_gnt,
    output est_t                  state,
    output logic [LINE_AW-1:0]    line,
    output kind_t                 kind,
    output logic                  has_data,
    output logic [LINE_BYTES-1:0] mask,
    output logic [DW-1:0]         data
);
    est_t                  state_q, state_d;
    logic [LINE_AW-1:0]    line_q;
    kind_t                 kind_q, sent_q;
    logic                  upg_q, has_q;
    logic [LINE_BYTES-1:0] mask_q, m_mask;
    logic [DW-1:0]         data_q, m_data, f_data;
    logic                  store_hit, need_upg;

    always_comb begin
        m_mask = mask_q | (merge ? in_mask : '0);
        for (int b = 0; b < LINE_BYTES; b++) begin
            m_data[b*8 +: 8] = (merge && in_mask[b]) ? in_data[b*8 +: 8] : data_q[b*8 +: 8];
            f_data[b*8 +: 8] = (rsp_has_data && !m_mask[b]) ? rsp_data[b*8 +: 8] : m_data[b*8 +: 8];
        end
        store_hit = merge && (in_kind != K_READ);
        need_upg  = upg_q || (store_hit && sent_q == K_READ);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            E_IDLE:    if (alloc)     state_d = E_ISSUE;
            E_ISSUE:   if (issue_gnt) state_d = E_WAIT;
            E_WAIT:    if (rsp_hit)   state_d = need_upg ? E_ISSUE : E_INSTALL;
            E_INSTALL: if (inst_gnt)  state_d = E_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= E_IDLE;
        else        state_q <= state_d;
    end

    // entry contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            kind_q <= K_READ;
            sent_q <= K_READ;
            upg_q  <= 1'b0;
            has_q  <= 1'b0;
            mask_q <= '0;
            data_q <= '0;
        end else begin
            unique case (state_q)
                E_IDLE: if (alloc) begin
                    line_q <= in_line;
                    kind_q <= in_kind;
                    sent_q <= K_READ;
                    mask_q <= in_mask;
                    data_q <= in_data;
                    upg_q  <= 1'b0;
                    has_q  <= 1'b0;
                end
                E_ISSUE: begin
                    if (merge) begin
                        mask_q <= m_mask;
                        data_q <= m_data;
                        kind_q <= kind_max(kind_q, in_kind);
                    end
                    if (issue_gnt) begin
                        sent_q <= kind_q;
                        if (store_hit && kind_q == K_READ) upg_q <= 1'b1;
                    end
                end
                E_WAIT: begin
                    if (merge) begin
                        mask_q <= m_mask;
                        data_q <= m_data;
                        kind_q <= kind_max(kind_q, in_kind);
                        if (store_hit && sent_q == K_READ) upg_q <= 1'b1;
                    end
                    if (rsp_hit) begin
                        data_q <= f_data;
                        has_q  <= has_q | rsp_has_data;
                        if (need_upg) begin
                            kind_q <= K_UPG;
                            upg_q  <= 1'b0;
                        end
                    end
                end
                E_INSTALL: ;
            endcase
        end
    end

    assign state    = state_q;
    assign line     = line_q;
    assign kind     = kind_q;
    assign has_data = has_q;
    assign mask     = mask_q;
    assign data     = data_q;

    // store bytes may only be installed under ownership (R8)
    assert_store_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == E_INSTALL && |mask_q) |-> (kind_q != K_READ));

    // responses only reach an entry that is waiting for one (R2)
    assert_rsp_in_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (state_q == E_WAIT));
endmodule

// File: rtl/miss_fill_buffer.sv
module miss_fill_buffer
    import mfb_pkg::*;
#(
    parameter int NUM_ENTRIES = 12,
    parameter int LINE_AW     = 26,
    parameter int LINE_BYTES  = 16,
    localparam int TAG_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int DW    = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [LINE_AW-1:0]    req_line,
    input  logic [1:0]            req_kind,
    input  logic [LINE_BYTES-1:0] req_mask,
    input  logic [DW-1:0]         req_data,
    output logic                  dn_valid,
    input  logic                  dn_ready,
    output logic [LINE_AW-1:0]    dn_line,
    output logic [1:0]            dn_kind,
    output logic [TAG_W-1:0]      dn_tag,
    input  logic                  rsp_valid,
    input  logic [TAG_W-1:0]      rsp_tag,
    input  logic                  rsp_has_data,
    input  logic [DW-1:0]         rsp_data,
    output logic                  fill_valid,
    output logic [LINE_AW-1:0]    fill_line,
    output logic [DW-1:0]         fill_data,
    output logic [LINE_BYTES-1:0] fill_byte_en,
    output logic                  fill_excl
);
    est_t                  st [NUM_ENTRIES];
    logic [LINE_AW-1:0]    ln [NUM_ENTRIES];
    kind_t                 kd [NUM_ENTRIES];
    logic [LINE_BYTES-1:0] mk [NUM_ENTRIES];
    logic [DW-1:0]         dt [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] hd, busy, match_vec, iss_req, ins_req;
    logic [NUM_ENTRIES-1:0] free_gnt, iss_gnt, ins_gnt, alloc, merge, issue_gnt, rsp_hit;
    logic [TAG_W-1:0]      free_idx, iss_idx, ins_idx;
    logic                  any_free, iss_any, ins_any, hit, hit_inst, accept;

    kind_t in_kind;
    assign in_kind = kind_t'(req_kind);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        assign busy[g]      = (st[g] != E_IDLE);
        assign match_vec[g] = busy[g] && (ln[g] == req_line);
        assign iss_req[g]   = (st[g] == E_ISSUE);
        assign ins_req[g]   = (st[g] == E_INSTALL);
        assign alloc[g]     = accept && !hit && free_gnt[g];
        assign merge[g]     = accept && match_vec[g];
        assign issue_gnt[g] = iss_gnt[g] && dn_ready;
        assign rsp_hit[g]   = rsp_valid && (rsp_tag == TAG_W'(g));

        mfb_entry #(.LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES)) u_ent (
            .clk(clk), .rst_n(rst_n),
            .alloc(alloc[g]), .merge(merge[g]),
            .in_line(req_line), .in_kind(in_kind), .in_mask(req_mask), .in_data(req_data),
            .issue_gnt(issue_gnt[g]),
            .rsp_hit(rsp_hit[g]), .rsp_has_data(rsp_has_data), .rsp_data(rsp_data),
            .inst_gnt(ins_gnt[g]),
            .state(st[g]), .line(ln[g]), .kind(kd[g]), .has_data(hd[g]),
            .mask(mk[g]), .data(dt[g])
        );
    end

    mfb_pick #(.N(NUM_ENTRIES)) u_free (.req(~busy),   .gnt(free_gnt), .idx(free_idx), .any(any_free));
    mfb_pick #(.N(NUM_ENTRIES)) u_iss  (.req(iss_req), .gnt(iss_gnt),  .idx(iss_idx),  .any(iss_any));
    mfb_pick #(.N(NUM_ENTRIES)) u_ins  (.req(ins_req), .gnt(ins_gnt),  .idx(ins_idx),  .any(ins_any));

    always_comb begin
        hit       = |match_vec;
        hit_inst  = |(match_vec & ins_req);
        req_ready = hit ? !hit_inst : any_free;
        accept    = req_valid && req_ready;
        dn_valid     = iss_any;
        dn_tag       = iss_idx;
        dn_line      = ln[iss_idx];
        dn_kind      = kd[iss_idx];
        fill_valid   = ins_any;
        fill_line    = ln[ins_idx];
        fill_data    = dt[ins_idx];
        fill_byte_en = hd[ins_idx] ? {LINE_BYTES{1'b1}} : mk[ins_idx];
        fill_excl    = (kd[ins_idx] != K_READ);
    end

    logic unused_free_idx;
    assign unused_free_idx = ^free_idx;

    assert_one_entry_per_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    assert_full_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy && !hit) |-> !req_ready);

    assert_read_fill_whole_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_excl) |-> (&fill_byte_en));
endmodule

// File: tb/tb_miss_fill_buffer.sv
module tb_miss_fill_buffer;
    localparam int NE = 12, AW = 26, LB = 16, DW = LB * 8, TW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_ready;
    logic [AW-1:0] req_line = '0;
    logic [1:0] req_kind = 2'b00;
    logic [LB-1:0] req_mask = '0;
    logic [DW-1:0] req_data = '0;
    logic dn_valid, dn_ready = 0;
    logic [AW-1:0] dn_line;
    logic [1:0] dn_kind;
    logic [TW-1:0] dn_tag;
    logic rsp_valid = 0, rsp_has_data = 0;
    logic [TW-1:0] rsp_tag = '0;
    logic [DW-1:0] rsp_data = '0;
    logic fill_valid, fill_excl;
    logic [AW-1:0] fill_line;
    logic [DW-1:0] fill_data;
    logic [LB-1:0] fill_byte_en;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    miss_fill_buffer #(.NUM_ENTRIES(NE), .LINE_AW(AW), .LINE_BYTES(LB)) dut (.*);

    function automatic logic [DW-1:0] mrg(input logic [DW-1:0] base, input logic [DW-1:0] st,
                                          input logic [LB-1:0] m);
        logic [DW-1:0] r = base;
        for (int b = 0; b < LB; b++) if (m[b]) r[b*8 +: 8] = st[b*8 +: 8];
        return r;
    endfunction

    function automatic logic [DW-1:0] bm(input logic [LB-1:0] m);
        logic [DW-1:0] r = '0;
        for (int b = 0; b < LB; b++) if (m[b]) r[b*8 +: 8] = 8'hFF;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [AW-1:0] l, input logic [1:0] k,
                          input logic [LB-1:0] m, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1; req_line = l; req_kind = k; req_mask = m; req_data = d;
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic take_dn(input string tag, input logic [AW-1:0] l, input logic [1:0] k,
                           input logic [TW-1:0] t);
        @(negedge clk);
        chk({tag, " dn_valid"}, DW'(dn_valid), DW'(1));
        chk({tag, " dn_line"}, DW'(dn_line), DW'(l));
        chk({tag, " dn_kind"}, DW'(dn_kind), DW'(k));
        chk({tag, " dn_tag"}, DW'(dn_tag), DW'(t));
        dn_ready = 1;
        @(posedge clk); #1;
        dn_ready = 0;
    endtask

    task automatic no_dn(input string tag);
        @(negedge clk);
        chk({tag, " no extra request"}, DW'(dn_valid), DW'(0));
    endtask

    task automatic give_rsp(input logic [TW-1:0] t, input logic h, input logic [DW-1:0] d);
        @(negedge clk);
        rsp_valid = 1; rsp_tag = t; rsp_has_data = h; rsp_data = d;
        @(posedge clk); #1;
        rsp_valid = 0;
    endtask

    task automatic check_fill(input string tag, input logic [AW-1:0] l, input logic x,
                              input logic [LB-1:0] be, input logic [DW-1:0] d);
        @(negedge clk);
        chk({tag, " fill_valid"}, DW'(fill_valid), DW'(1));
        chk({tag, " fill_line"}, DW'(fill_line), DW'(l));
        chk({tag, " fill_excl"}, DW'(fill_excl), DW'(x));
        chk({tag, " fill_byte_en"}, DW'(fill_byte_en), DW'(be));
        chk({tag, " fill_data"}, fill_data & bm(be), d & bm(be));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 req_ready", DW'(req_ready), DW'(1));
        chk("R1 dn_valid", DW'(dn_valid), DW'(0));
        chk("R1 fill_valid", DW'(fill_valid), DW'(0));
    endtask

    task automatic t_read_miss;
        logic [DW-1:0] d = {4{32'hA5A5_0001}};
        do_req(26'h0_0100, 2'b00, '0, '0);
        take_dn("R2 read", 26'h0_0100, 2'b00, 0);
        no_dn("R2 read");
        give_rsp(0, 1, d);
        check_fill("R8 read", 26'h0_0100, 0, '1, d);
    endtask

    task automatic t_store_merge;
        logic [DW-1:0] s1 = {4{32'h1111_2222}}, s2 = {4{32'h3333_4444}}, d = {4{32'hDEAD_BEEF}};
        do_req(26'h0_0200, 2'b10, 16'h000F, s1);
        do_req(26'h0_0200, 2'b10, 16'h00F0, s2);
        take_dn("R3 merge", 26'h0_0200, 2'b10, 0);
        no_dn("R3 merge");
        give_rsp(0, 1, d);
        check_fill("R6 store over fill", 26'h0_0200, 1, '1,
                   mrg(mrg(d, s1, 16'h000F), s2, 16'h00F0));
    endtask

    task automatic t_read_then_store;
        logic [DW-1:0] s = {4{32'h0000_0077}}, d = {4{32'h5555_6666}};
        do_req(26'h0_0300, 2'b00, '0, '0);
        do_req(26'h0_0300, 2'b10, 16'h0001, s);
        take_dn("R4 promote", 26'h0_0300, 2'b10, 0);
        no_dn("R4 promote");
        give_rsp(0, 1, d);
        check_fill("R4 promote", 26'h0_0300, 1, '1, mrg(d, s, 16'h0001));
    endtask

    task automatic t_late_store;
        logic [DW-1:0] s = {4{32'h00AB_0000}}, d = {4{32'h7777_8888}};
        do_req(26'h0_0400, 2'b00, '0, '0);
        take_dn("R5 read sent", 26'h0_0400, 2'b00, 0);
        do_req(26'h0_0400, 2'b10, 16'h0100, s);
        no_dn("R5 before response");
        give_rsp(0, 1, d);
        @(negedge clk);
        chk("R5 no install yet", DW'(fill_valid), DW'(0));
        take_dn("R5 extra upgrade", 26'h0_0400, 2'b01, 0);
        no_dn("R5 single extra");
        give_rsp(0, 0, '0);
        check_fill("R5 install", 26'h0_0400, 1, '1, mrg(d, s, 16'h0100));
    endtask

    task automatic t_upgrade;
        logic [DW-1:0] s = {4{32'hC0FF_EE00}};
        do_req(26'h0_0500, 2'b01, 16'hF000, s);
        take_dn("R7 upgrade", 26'h0_0500, 2'b01, 0);
        give_rsp(0, 0, {DW{1'b1}});
        check_fill("R7 upgrade", 26'h0_0500, 1, 16'hF000, s);
    endtask

    task automatic t_full;
        for (int i = 0; i < NE; i++) do_req(AW'(26'h0_1000 + i), 2'b00, '0, '0);
        @(negedge clk);
        req_valid = 1; req_kind = 2'b00; req_mask = '0; req_line = 26'h0_2000;
        #1 chk("R9 full new line stalls", DW'(req_ready), DW'(0));
        req_line = 26'h0_1005;
        #1 chk("R9 full tracked line accepted", DW'(req_ready), DW'(1));
        req_valid = 0;
        for (int i = 0; i < NE; i++) take_dn("R9 drain", AW'(26'h0_1000 + i), 2'b00, TW'(i));
        for (int i = 0; i < NE; i++) begin
            give_rsp(TW'(i), 1, {4{32'(i)}});
            check_fill("R9 drain", AW'(26'h0_1000 + i), 0, '1, {4{32'(i)}});
        end
    endtask

    task automatic t_install_stall;
        do_req(26'h0_0600, 2'b00, '0, '0);
        take_dn("R10 setup", 26'h0_0600, 2'b00, 0);
        give_rsp(0, 1, {4{32'h600D_600D}});
        req_valid = 1; req_kind = 2'b00; req_mask = '0; req_line = 26'h0_0600;
        #1 chk("R10 install stall", DW'(req_ready), DW'(0));
        req_line = 26'h0_0601;
        #1 chk("R10 other line free", DW'(req_ready), DW'(1));
        req_valid = 0;
        check_fill("R10 install", 26'h0_0600, 0, '1, {4{32'h600D_600D}});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_read_miss();
        t_store_merge();
        t_read_then_store();
        t_late_store();
        t_upgrade();
        t_full();
        t_install_stall();
        repeat (3) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule